// File: doc/BRIEF.md
# Slave Bus Hold and Tristate Controller

This block controls the external bus pins of a processor that can run as the slave in a two-processor system. It decides when the processor hands the shared bus to the other master and which of its pin groups it drives at each moment. There are three groups: the address and control group, the data bus, and the data-complete strobe. An active-low hold request is granted with an active-low hold acknowledge. While the hold is granted, the address and control group is released. The data bus and the strobe are driven only when the other master reaches into this processor's internal memory.

When the mode strap selects slave mode, every pin group stays undriven throughout reset. If the hold request is asserted during reset and never withdrawn, the pins stay released after reset ends, without a gap. The core can set and clear an exclusive-access lock with single-cycle strobes. While the lock is set, no new hold is granted and external accesses to internal memory are refused. A hold that is already granted is kept. All external inputs pass through synchronizers, and all outputs come from registers.

Top module: `slave_hold_ctrl`

## Requirements
- R1: While rst_n is low, from the first clock edge of reset onward, addr_oe_o, data_oe_o and dc_oe_o are 0 and hold_ack_n_o is 1.
- R2: In slave mode with no hold request during reset, the first clock edge after rst_n rises gives normal driving: hold_ack_n_o=1, addr_oe_o=1, dc_oe_o=1, and data_oe_o equal to core_dout_en_i.
- R3: In slave mode (slave_mode_i=1), a hold request (hold_req_n_i=0) held through reset and into release gives hold_ack_n_o=0 with all three enables 0 from the first edge after release. The enables never return to 1 in between, and core_busy_i has no effect on this.
- R4: In master mode (slave_mode_i=0), a hold request held through reset gets no reset-time grant. With core_busy_i=1 at release, the outputs drive normally. The mode strap is captured only while in reset.
- R5: Outside reset, with the lock clear and core_busy_i=0, hold_ack_n_o falls on the third rising edge after hold_req_n_i falls: two synchronizer edges plus one register edge. While core_busy_i=1, no new grant is made, and the grant follows one edge after core_busy_i drops.
- R6: hold_ack_n_o returns to 1 and addr_oe_o to 1 on the third rising edge after hold_req_n_i rises.
- R7: While hold_ack_n_o=0, addr_oe_o is 0.
- R8: During the hold, data_oe_o=1 only when cs_n_i=0 and rd_wr_i=1 (1 means read) and the lock is clear. Outside the hold, data_oe_o follows core_dout_en_i one edge later.
- R9: During the hold, dc_oe_o=1 only when cs_n_i=0 and the lock is clear. Outside the hold, dc_oe_o=1.
- R10: A lock_set_i pulse sets the lock and a lock_clr_i pulse clears it. When both pulse together, the lock ends up set. While the lock is set, a hold request is not granted. After a clear, the grant follows on the second edge counted from the clear pulse's edge.
- R11: A hold granted before the lock is set stays granted. However, external accesses are refused (data_oe_o=0, dc_oe_o=0) from the second edge after the set pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| slave_mode_i | input | 1 | Mode strap, 1 selects slave mode |
| hold_req_n_i | input | 1 | Hold request from the other master, active low |
| cs_n_i | input | 1 | External chip select for internal memory, active low |
| rd_wr_i | input | 1 | External access direction, 1 read, 0 write |
| lock_set_i | input | 1 | Core strobe from a locked load |
| lock_clr_i | input | 1 | Core strobe from an unlocking store |
| core_busy_i | input | 1 | Core has an internal bus cycle in progress |
| core_dout_en_i | input | 1 | Core wants to drive the data bus (outside hold) |
| hold_ack_n_o | output | 1 | Hold acknowledge, active low |
| addr_oe_o | output | 1 | Output enable for address and control group |
| data_oe_o | output | 1 | Output enable for the data bus |
| dc_oe_o | output | 1 | Output enable for the data-complete strobe |

## Verification
The assertions assume that the lock strobes, core_busy_i and core_dout_en_i are synchronous to clk, and that the reset-time grant is only meaningful when the request stays steady from the start of reset. The stimulus therefore changes every input at the falling edge, holds each lock strobe for exactly one rising edge, and keeps each reset long enough for the two-flop synchronizers to fill. The hold request and the mode strap are set before reset begins, so the reset-held path always sees a request that never drops.

// File: rtl/shc_pkg.sv
package shc_pkg;
    localparam int SHC_NSYNC = 4;
    localparam int SYN_MODE  = 0;
    localparam int SYN_REQ   = 1;
    localparam int SYN_CS    = 2;
    localparam int SYN_RD    = 3;

    typedef struct packed {
        logic hack_n;
        logic addr_oe;
        logic data_oe;
        logic dc_oe;
    } shc_pins_t;

    typedef struct packed {
        logic slave;
        logic seen;
        logic dropped;
        logic granted;
    } shc_arb_t;
endpackage

// File: rtl/shc_sync.sv
module shc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] stage_q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk) stage_q <= d_i;
            end else begin : g_next
                always_ff @(posedge clk) stage_q <= g_stage[g-1].stage_q;
            end
        end
    endgenerate

    assign q_o = g_stage[STAGES-1].stage_q;
endmodule

// File: rtl/shc_lock.sv
module shc_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic lock_o
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (!rst_n)     lock_d = 1'b0;
        else if (set_i) lock_d = 1'b1;
        else if (clr_i) lock_d = 1'b0;
    end

    always_ff @(posedge clk) lock_q <= lock_d;

    assign lock_o = lock_q;

    AST_LOCK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> lock_q); // R10
endmodule

// File: rtl/shc_arb.sv
module shc_arb
    import shc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slave_s_i,
    input  logic req_s_i,
    input  logic lock_i,
    input  logic busy_i,
    output logic granted_d_o
);
    shc_arb_t arb_d, arb_q;

    always_comb begin
        arb_d = arb_q;
        if (!rst_n) begin
            arb_d.slave   = slave_s_i;
            arb_d.seen    = arb_q.seen | req_s_i;
            arb_d.dropped = arb_q.dropped | (arb_q.seen & ~req_s_i);
            arb_d.granted = slave_s_i & req_s_i & ~arb_q.dropped;
        end else begin
            arb_d.seen    = 1'b0;
            arb_d.dropped = 1'b0;
            if (arb_q.granted) arb_d.granted = req_s_i;
            else               arb_d.granted = req_s_i & ~lock_i & ~busy_i;
        end
    end

    always_ff @(posedge clk) arb_q <= arb_d;

    assign granted_d_o = arb_d.granted;

    AST_GRANT_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arb_q.granted) && $past(rst_n)) |-> $past(!lock_i && !busy_i)); // R10
    AST_HOLD_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.granted && req_s_i) |=> arb_q.granted); // R11
    AST_RELEASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.granted && !req_s_i) |=> !arb_q.granted); // R6
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(arb_q.slave)); // R4
endmodule

// File: rtl/shc_pins.sv
module shc_pins
    import shc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      granted_d_i,
    input  logic      cs_s_i,
    input  logic      rd_s_i,
    input  logic      lock_i,
    input  logic      dout_en_i,
    output shc_pins_t pins_o
);
    shc_pins_t pins_d, pins_q;
    logic      accept;

    always_comb begin
        accept = cs_s_i & ~lock_i;
        pins_d = pins_q;
        if (!rst_n) begin
            pins_d = '{hack_n: 1'b1, addr_oe: 1'b0, data_oe: 1'b0, dc_oe: 1'b0};
        end else if (granted_d_i) begin
            pins_d.hack_n  = 1'b0;
            pins_d.addr_oe = 1'b0;
            pins_d.data_oe = accept & rd_s_i;
            pins_d.dc_oe   = accept;
        end else begin
            pins_d.hack_n  = 1'b1;
            pins_d.addr_oe = 1'b1;
            pins_d.data_oe = dout_en_i;
            pins_d.dc_oe   = 1'b1;
        end
    end

    always_ff @(posedge clk) pins_q <= pins_d;

    assign pins_o = pins_q;

    AST_DATA_NEEDS_DC: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_q.hack_n && pins_q.data_oe) |-> pins_q.dc_oe); // R8
    AST_LOCK_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && granted_d_i) |=> (!pins_q.dc_oe && !pins_q.data_oe)); // R11
endmodule

// File: rtl/slave_hold_ctrl.sv
module slave_hold_ctrl
    import shc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode_i,
    input  logic hold_req_n_i,
    input  logic cs_n_i,
    input  logic rd_wr_i,
    input  logic lock_set_i,
    input  logic lock_clr_i,
    input  logic core_busy_i,
    input  logic core_dout_en_i,
    output logic hold_ack_n_o,
    output logic addr_oe_o,
    output logic data_oe_o,
    output logic dc_oe_o
);
    logic [SHC_NSYNC-1:0] raw_in, syn_out;
    logic                 lock_q;
    logic                 granted_d;
    shc_pins_t            pins;

    always_comb begin
        raw_in           = '0;
        raw_in[SYN_MODE] = slave_mode_i;
        raw_in[SYN_REQ]  = ~hold_req_n_i;
        raw_in[SYN_CS]   = ~cs_n_i;
        raw_in[SYN_RD]   = rd_wr_i;
    end

    shc_sync #(.WIDTH(SHC_NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (raw_in),
        .q_o (syn_out)
    );

    shc_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lock_set_i),
        .clr_i  (lock_clr_i),
        .lock_o (lock_q)
    );

    shc_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .slave_s_i   (syn_out[SYN_MODE]),
        .req_s_i     (syn_out[SYN_REQ]),
        .lock_i      (lock_q),
        .busy_i      (core_busy_i),
        .granted_d_o (granted_d)
    );

    shc_pins u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .granted_d_i (granted_d),
        .cs_s_i      (syn_out[SYN_CS]),
        .rd_s_i      (syn_out[SYN_RD]),
        .lock_i      (lock_q),
        .dout_en_i   (core_dout_en_i),
        .pins_o      (pins)
    );

    assign hold_ack_n_o = pins.hack_n;
    assign addr_oe_o    = pins.addr_oe;
    assign data_oe_o    = pins.data_oe;
    assign dc_oe_o      = pins.dc_oe;

    AST_HOLD_ADDR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n_o |-> !addr_oe_o); // R7
endmodule

// File: tb/slave_hold_ctrl_tb.sv
module slave_hold_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n, slave_mode, hold_req_n, cs_n, rd_wr;
    logic lock_set, lock_clr, core_busy, core_dout_en;
    logic hold_ack_n, addr_oe, data_oe, dc_oe;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    slave_hold_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .slave_mode_i   (slave_mode),
        .hold_req_n_i   (hold_req_n),
        .cs_n_i         (cs_n),
        .rd_wr_i        (rd_wr),
        .lock_set_i     (lock_set),
        .lock_clr_i     (lock_clr),
        .core_busy_i    (core_busy),
        .core_dout_en_i (core_dout_en),
        .hold_ack_n_o   (hold_ack_n),
        .addr_oe_o      (addr_oe),
        .data_oe_o      (data_oe),
        .dc_oe_o        (dc_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag, input logic h, input logic a, input logic d, input logic c);
        chk(tag, "hold_ack_n", hold_ack_n, h);
        chk(tag, "addr_oe", addr_oe, a);
        chk(tag, "data_oe", data_oe, d);
        chk(tag, "dc_oe", dc_oe, c);
    endtask

    task automatic pulse(input logic s, input logic c);
        lock_set = s;
        lock_clr = c;
        step(1);
        lock_set = 1'b0;
        lock_clr = 1'b0;
    endtask

    task automatic enter_reset(input logic slave, input logic req_n, input logic busy);
        rst_n      = 1'b0;
        slave_mode = slave;
        hold_req_n = req_n;
        core_busy  = busy;
        cs_n       = 1'b1;
        rd_wr      = 1'b0;
        step(6);
    endtask

    // R1 and R2
    task automatic t_reset_and_normal();
        core_dout_en = 1'b1;
        enter_reset(1'b1, 1'b1, 1'b0);
        chk_pins("R1", 1'b1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk_pins("R2", 1'b1, 1'b1, 1'b1, 1'b1);
        core_dout_en = 1'b0;
        step(1);
        chk("R8", "data_oe follows core outside hold", data_oe, 1'b0);
    endtask

    // R3 and R6
    task automatic t_reset_held();
        core_dout_en = 1'b1;
        enter_reset(1'b1, 1'b0, 1'b1);
        chk_pins("R1", 1'b1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        chk_pins("R3", 1'b1, 1'b0, 1'b0, 1'b0);
        step(1);
        chk_pins("R3", 1'b0, 1'b0, 1'b0, 1'b0);
        core_busy  = 1'b0;
        hold_req_n = 1'b1;
        step(2);
        chk("R6", "ack before third edge", hold_ack_n, 1'b0);
        step(1);
        chk("R6", "ack released", hold_ack_n, 1'b1);
        chk("R6", "addr_oe back", addr_oe, 1'b1);
    endtask

    // R4 and R5
    task automatic t_master_mode();
        core_dout_en = 1'b0;
        enter_reset(1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        step(2);
        chk_pins("R4", 1'b1, 1'b1, 1'b0, 1'b1);
        core_busy = 1'b0;
        step(1);
        chk("R5", "grant after busy drops", hold_ack_n, 1'b0);
        chk("R7", "addr_oe off in hold", addr_oe, 1'b0);
    endtask

    // R5 and R7
    task automatic t_grant_latency();
        enter_reset(1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        step(2);
        hold_req_n = 1'b0;
        step(2);
        chk("R5", "no ack after two edges", hold_ack_n, 1'b1);
        step(1);
        chk("R5", "ack on third edge", hold_ack_n, 1'b0);
        chk("R7", "addr_oe off in hold", addr_oe, 1'b0);
        hold_req_n = 1'b1;
        step(4);
        core_busy  = 1'b1;
        hold_req_n = 1'b0;
        step(6);
        chk("R5", "busy blocks grant", hold_ack_n, 1'b1);
        core_busy = 1'b0;
        step(1);
        chk("R5", "grant after busy", hold_ack_n, 1'b0);
    endtask

    // R8 and R9
    task automatic t_ext_access();
        cs_n  = 1'b1;
        rd_wr = 1'b1;
        step(4);
        chk_pins("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        cs_n = 1'b0;
        step(4);
        chk_pins("R8", 1'b0, 1'b0, 1'b1, 1'b1);
        rd_wr = 1'b0;
        step(4);
        chk_pins("R8", 1'b0, 1'b0, 1'b0, 1'b1);
        cs_n = 1'b1;
        step(4);
        chk_pins("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // R10 and R11
    task automatic t_lock();
        enter_reset(1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        step(2);
        pulse(1'b1, 1'b0);
        hold_req_n = 1'b0;
        step(8);
        chk("R10", "lock blocks grant", hold_ack_n, 1'b1);
        pulse(1'b0, 1'b1);
        chk("R10", "no grant on clear edge", hold_ack_n, 1'b1);
        step(1);
        chk("R10", "grant after clear", hold_ack_n, 1'b0);
        cs_n  = 1'b0;
        rd_wr = 1'b1;
        step(4);
        chk("R8", "read while unlocked", data_oe, 1'b1);
        pulse(1'b1, 1'b0);
        step(1);
        chk_pins("R11", 1'b0, 1'b0, 1'b0, 1'b0);
        step(3);
        chk("R11", "hold kept under lock", hold_ack_n, 1'b0);
        pulse(1'b1, 1'b1);
        step(2);
        chk("R10", "set wins while set", dc_oe, 1'b0);
        pulse(1'b0, 1'b1);
        step(1);
        chk("R10", "clear reopens access", dc_oe, 1'b1);
        pulse(1'b1, 1'b1);
        step(1);
        chk("R10", "set wins from clear", dc_oe, 1'b0);
        pulse(1'b0, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; slave_mode = 1'b1; hold_req_n = 1'b1; cs_n = 1'b1;
        rd_wr = 1'b0; lock_set = 1'b0; lock_clr = 1'b0; core_busy = 1'b0;
        core_dout_en = 1'b0;
        t_reset_and_normal();
        t_reset_held();
        t_master_mode();
        t_grant_latency();
        t_ext_access();
        t_lock();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run act=hung exp=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule